// File: doc/BRIEF.md
# Cipher Event Interrupt Controller

This block gathers four event pulses from a block-cipher accelerator (cipher finished, cipher started, transfer channel A finished, transfer channel B finished) into sticky raw flags and combines them with an enable mask into a single interrupt line. Software reaches it through a small word-addressed register port. It can read the raw flags, the mask and the masked flags. It can force or drop raw flags with write-one registers, and it can change the mask either with a direct write or through separate write-one-to-set and write-one-to-clear registers.

Each source also has an auto-clear enable. When the accelerator reports an access (read or write, by software or by a transfer engine) to the last word of any of its data views, every raw flag whose auto-clear enable is high is dropped. Streaming software can then acknowledge events without a separate clear write. The event generation itself happens outside this block.

Register select (`reg_addr`): 0 mask (read/write), 1 raw flags (read only), 2 masked flags (read only), 3 raw set, 4 raw clear, 5 mask set, 6 mask clear. The write-only selects read as zero.

Top module: `evt_irq_ctrl`

## Requirements
- R1: Flag bit positions are fixed: bit 0 cipher done, bit 1 cipher start, bit 2 channel A done, bit 3 channel B done. Bits 31:4 of every readable register read as zero.
- R2: Reading select 2 returns the raw flags ANDed with the mask.
- R3: A write to select 3 sets each raw flag whose data bit is 1. Zero bits leave their flags unchanged.
- R4: A write to select 4 clears each raw flag whose data bit is 1. Zero bits leave their flags unchanged.
- R5: A write to select 5 sets the mask bits given by the 1 bits of the data, and a write to select 6 clears them. Other mask bits are kept.
- R6: A write to select 0 loads the mask directly from data bits 3:0.
- R7: A pulse on `w3_access` clears every raw flag whose `autoclr_en` bit is 1 and leaves the other flags unchanged.
- R8: While `rst` is high, all raw flags, all mask bits and `irq_o` are 0.
- R9: If a set (event pulse or select 3 write) meets a clear (select 4 write or auto-clear) on the same flag in the same cycle, the flag ends up set.
- R10: `irq_o` is a register holding the OR of the masked flags. It follows a change of the masked flags one clock later.
- R11: Writes to select 1 and select 2 change neither the raw flags nor the mask.
- R12: A high bit of `evt_pulse` sets the matching raw flag at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_pulse | input | 4 | One-cycle event pulses, one bit per source |
| w3_access | input | 1 | Pulse for an access to the last word of any data view |
| autoclr_en | input | 4 | Per-source auto-clear enable |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register, combinational |
| irq_o | output | 1 | Registered interrupt line |

## Verification
Two things can land on the same raw flag in one cycle: a hardware event or software set, and a clear from the clear register or from a last-word access. The bench provokes both pairings in one cycle by pulsing `evt_pulse` together with a clear-register write on one bit, and together with `w3_access` under an enabled auto-clear on another. It then reads the raw flags and expects both bits set. A negative case with the auto-clear enable low confirms that the access alone leaves flags untouched.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int N_SRC  = 4;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_MASK      = 3'd0,
        SEL_RAW       = 3'd1,
        SEL_MASKED    = 3'd2,
        SEL_SET       = 3'd3,
        SEL_CLR       = 3'd4,
        SEL_MASK_SET  = 3'd5,
        SEL_MASK_CLR  = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic mask_load;
        logic mask_set;
        logic mask_clr;
        logic raw_set;
        logic raw_clr;
    } wr_dec_t;

    // Sets take precedence over clears.
    function automatic logic [N_SRC-1:0] merge_flags(
        input logic [N_SRC-1:0] cur,
        input logic [N_SRC-1:0] set_v,
        input logic [N_SRC-1:0] clr_v
    );
        return (cur & ~clr_v) | set_v;
    endfunction

endpackage

// File: rtl/evt_raw_flags.sv
module evt_raw_flags
    import evt_irq_pkg::*;
#(
    parameter int NS = N_SRC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NS-1:0] hw_set,
    input  logic [NS-1:0] sw_set,
    input  logic [NS-1:0] sw_clr,
    input  logic [NS-1:0] auto_clr,
    output logic [NS-1:0] raw_q
);
    for (genvar b = 0; b < NS; b++) begin : g_flag
        logic nxt;
        always_comb begin
            nxt = hw_set[b] | sw_set[b] | (raw_q[b] & ~(sw_clr[b] | auto_clr[b]));
        end
        always_ff @(posedge clk) begin
            if (rst) raw_q[b] <= 1'b0;
            else     raw_q[b] <= nxt;
        end
    end
endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg
    import evt_irq_pkg::*;
#(
    parameter int NS = N_SRC
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_dec_t       dec,
    input  logic [NS-1:0] wbits,
    output logic [NS-1:0] mask_q
);
    logic [NS-1:0] mask_d;

    always_comb begin
        mask_d = mask_q;
        if (dec.mask_load)     mask_d = wbits;
        else if (dec.mask_set) mask_d = merge_flags(mask_q, wbits, '0);
        else if (dec.mask_clr) mask_d = merge_flags(mask_q, '0, wbits);
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_d;
    end
endmodule

// File: rtl/evt_read_mux.sv
module evt_read_mux
    import evt_irq_pkg::*;
#(
    parameter int NS = N_SRC,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] sel,
    input  logic [NS-1:0] raw_q,
    input  logic [NS-1:0] mask_q,
    output logic [DW-1:0] rdata
);
    localparam int PAD_W = DW - NS;

    always_comb begin
        unique case (reg_sel_e'(sel))
            SEL_MASK:   rdata = {{PAD_W{1'b0}}, mask_q};
            SEL_RAW:    rdata = {{PAD_W{1'b0}}, raw_q};
            SEL_MASKED: rdata = {{PAD_W{1'b0}}, raw_q & mask_q};
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int NS = N_SRC,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NS-1:0] evt_pulse,
    input  logic          w3_access,
    input  logic [NS-1:0] autoclr_en,
    input  logic          reg_wr_en,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_o
);
    wr_dec_t       dec;
    logic [NS-1:0] wbits;
    logic [NS-1:0] raw_q;
    logic [NS-1:0] mask_q;
    logic [NS-1:0] auto_clr;
    logic          unused_hi;

    assign wbits     = reg_wdata[NS-1:0];
    assign unused_hi = ^reg_wdata[DW-1:NS];
    assign auto_clr  = w3_access ? autoclr_en : '0;

    always_comb begin
        dec           = '0;
        dec.mask_load = reg_wr_en && (reg_sel_e'(reg_addr) == SEL_MASK);
        dec.mask_set  = reg_wr_en && (reg_sel_e'(reg_addr) == SEL_MASK_SET);
        dec.mask_clr  = reg_wr_en && (reg_sel_e'(reg_addr) == SEL_MASK_CLR);
        dec.raw_set   = reg_wr_en && (reg_sel_e'(reg_addr) == SEL_SET);
        dec.raw_clr   = reg_wr_en && (reg_sel_e'(reg_addr) == SEL_CLR);
    end

    evt_raw_flags #(.NS(NS)) u_raw (
        .clk      (clk),
        .rst      (rst),
        .hw_set   (evt_pulse),
        .sw_set   (dec.raw_set ? wbits : '0),
        .sw_clr   (dec.raw_clr ? wbits : '0),
        .auto_clr (auto_clr),
        .raw_q    (raw_q)
    );

    evt_mask_reg #(.NS(NS)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .dec    (dec),
        .wbits  (wbits),
        .mask_q (mask_q)
    );

    evt_read_mux #(.NS(NS), .DW(DW), .AW(AW)) u_rd (
        .sel    (reg_addr),
        .raw_q  (raw_q),
        .mask_q (mask_q),
        .rdata  (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |(raw_q & mask_q);
    end
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk
    import evt_irq_pkg::*;
#(
    parameter int NS = N_SRC,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input logic          clk,
    input logic          rst,
    input logic [NS-1:0] evt_pulse,
    input logic          w3_access,
    input logic [NS-1:0] autoclr_en,
    input logic          reg_wr_en,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic          irq_o,
    input logic [NS-1:0] raw_q,
    input logic [NS-1:0] mask_q
);
    logic wr_set, wr_clr, wr_mset, wr_ro;
    assign wr_set  = reg_wr_en && (reg_addr == SEL_SET);
    assign wr_clr  = reg_wr_en && (reg_addr == SEL_CLR);
    assign wr_mset = reg_wr_en && (reg_addr == SEL_MASK_SET);
    assign wr_ro   = reg_wr_en && ((reg_addr == SEL_RAW) || (reg_addr == SEL_MASKED));

    // R8
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (raw_q == '0 && mask_q == '0 && irq_o == 1'b0));

    // R12 (also the set side of R9)
    event_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt_pulse) |=> ((raw_q & $past(evt_pulse)) == $past(evt_pulse)));

    // R10
    irq_follows_masked_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past(|(raw_q & mask_q))));

    // R4
    clear_write_drops_chk: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((raw_q & $past(reg_wdata[NS-1:0]) & ~$past(evt_pulse)) == '0));

    // R7
    auto_clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (w3_access && !wr_set) |=> ((raw_q & $past(autoclr_en) & ~$past(evt_pulse)) == '0));

    // R5
    mask_set_raises_chk: assert property (@(posedge clk) disable iff (rst)
        wr_mset |=> ((mask_q & $past(reg_wdata[NS-1:0])) == $past(reg_wdata[NS-1:0])));

    // R11
    ro_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ro && evt_pulse == '0 && !w3_access) |=> ($stable(raw_q) && $stable(mask_q)));
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.NS(NS), .DW(DW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .evt_pulse  (evt_pulse),
    .w3_access  (w3_access),
    .autoclr_en (autoclr_en),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .irq_o      (irq_o),
    .raw_q      (raw_q),
    .mask_q     (mask_q)
);

// File: tb/evt_irq_ctrl_tb.sv
`timescale 1ns/1ps
module evt_irq_ctrl_tb;
    import evt_irq_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_SRC-1:0]  evt_pulse = '0;
    logic              w3_access = 1'b0;
    logic [N_SRC-1:0]  autoclr_en = '0;
    logic              reg_wr_en = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    evt_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .w3_access(w3_access),
        .autoclr_en(autoclr_en), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    // kind: 0 write, 1 event, 2 last-word access, 3 idle
    typedef struct packed {
        logic [1:0] kind;
        logic [2:0] addr;
        logic [3:0] data;
        logic [3:0] ac;
        logic [2:0] rd;
        logic [3:0] expv;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 3'd3, 4'b0101, 4'b0000, 3'd1, 4'b0101, 8'd3 },  // R3
        '{2'd0, 3'd5, 4'b0011, 4'b0000, 3'd2, 4'b0001, 8'd5 },  // R5 via masked
        '{2'd0, 3'd4, 4'b0001, 4'b0000, 3'd1, 4'b0100, 8'd4 },  // R4
        '{2'd1, 3'd0, 4'b1010, 4'b0000, 3'd1, 4'b1110, 8'd12},  // R12
        '{2'd0, 3'd0, 4'b1100, 4'b0000, 3'd0, 4'b1100, 8'd6 },  // R6
        '{2'd3, 3'd0, 4'b0000, 4'b0000, 3'd2, 4'b1100, 8'd2 },  // R2
        '{2'd0, 3'd6, 4'b0100, 4'b0000, 3'd0, 4'b1000, 8'd5 },  // R5
        '{2'd2, 3'd0, 4'b0000, 4'b0110, 3'd1, 4'b1000, 8'd7 },  // R7
        '{2'd0, 3'd1, 4'b1111, 4'b0000, 3'd1, 4'b1000, 8'd11},  // R11
        '{2'd0, 3'd2, 4'b1111, 4'b0000, 3'd0, 4'b1000, 8'd11},  // R11
        '{2'd0, 3'd3, 4'b0000, 4'b0000, 3'd1, 4'b1000, 8'd3 },  // R3 zero bits
        '{2'd0, 3'd4, 4'b0000, 4'b0000, 3'd1, 4'b1000, 8'd4 }   // R4 zero bits
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R8 reset state
        rd(3'd0, v); check("R8 mask", v, 32'h0);
        rd(3'd1, v); check("R8 raw", v, 32'h0);
        check("R8 irq", {31'b0, irq_o}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            case (VEC[i].kind)
                2'd0: begin reg_wr_en = 1'b1; reg_addr = VEC[i].addr; reg_wdata = {28'b0, VEC[i].data}; end
                2'd1: evt_pulse = VEC[i].data;
                2'd2: begin w3_access = 1'b1; autoclr_en = VEC[i].ac; end
                default: ;
            endcase
            @(negedge clk);
            reg_wr_en = 1'b0; reg_wdata = '0; evt_pulse = '0; w3_access = 1'b0; autoclr_en = '0;
            rd(VEC[i].rd, v);
            checks++;
            if (v !== {28'b0, VEC[i].expv}) begin
                errors++;
                $display("FAIL vector %0d req R%0d actual=%h expected=%h",
                         i, VEC[i].req, v, {28'b0, VEC[i].expv});
            end
        end

        // R10: raw 1000, mask 1000 -> irq high; drop mask, irq falls one clock later
        check("R10 irq high", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 3'd6; reg_wdata = 32'h8;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
        check("R10 irq lag", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        check("R10 irq low", {31'b0, irq_o}, 32'h0);

        // R9: set meets clear-register write (bit 0) and auto-clear (bit 1)
        @(negedge clk);
        evt_pulse = 4'b0011; reg_wr_en = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h3;
        w3_access = 1'b1; autoclr_en = 4'b0011;
        @(negedge clk);
        evt_pulse = '0; reg_wr_en = 1'b0; reg_wdata = '0; w3_access = 1'b0; autoclr_en = '0;
        rd(3'd1, v); check("R9 set wins", v, 32'hB);

        // R7 negative: access with enables low keeps flags
        @(negedge clk);
        w3_access = 1'b1; autoclr_en = '0;
        @(negedge clk);
        w3_access = 1'b0;
        rd(3'd1, v); check("R7 disabled", v, 32'hB);

        // R1: upper bits read zero, bit order
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd1, v); check("R1 upper zero", v, 32'hF);
        wr(3'd4, 32'h0000_000E);
        rd(3'd1, v); check("R1 bit0 done", v, 32'h1);
        wr(3'd0, 32'hFFFF_FFF4);
        rd(3'd0, v); check("R1 mask upper", v, 32'h4);
        rd(3'd3, v); check("R1 write-only reads 0", v, 32'h0);

        // R8 mid-run reset
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        rd(3'd1, v); check("R8 raw rst", v, 32'h0);
        rd(3'd0, v); check("R8 mask rst", v, 32'h0);
        check("R8 irq rst", {31'b0, irq_o}, 32'h0);
        rst = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule